// File: doc/BRIEF.md
# Sixteen-bit ALU with branch flags

This block is the arithmetic and logic unit of a small 16-bit processor. It is purely combinational. It takes two 16-bit operands and a 3-bit operation code. It returns a 16-bit result and two flags that the branch logic reads.

The zero flag goes high when the result is all zeros. Subtracting one register from another therefore reports whether the two are equal. The sign flag copies the result's most significant bit, so a clear sign flag means the value is zero or positive.

The block supports six operations:
- add and subtract, both wrapping modulo 2^16;
- bitwise complement of A;
- bitwise AND;
- logical left shift and logical right shift, each by the low three bits of B.

The two remaining operation codes give a result of zero. There is no carry output and no overflow output.

Top module: `alu16_core`

## Requirements
- R1: op_i=000 (add) gives result_o = (a_i + b_i) mod 2^16, with no overflow indication.
- R2: op_i=001 (subtract) gives result_o = (a_i - b_i) mod 2^16.
- R3: op_i=010 gives result_o = ~a_i, and b_i has no effect on the result.
- R4: op_i=011 gives result_o = a_i & b_i.
- R5: op_i=100 gives result_o = a_i shifted left by b_i[2:0] with zeros entering at bit 0; b_i[15:3] has no effect.
- R6: op_i=101 gives result_o = a_i shifted right by b_i[2:0] with zeros entering at bit 15; b_i[15:3] has no effect.
- R7: op_i=110 and op_i=111 give result_o = 0 for any operands.
- R8: zero_o is 1 exactly when result_o is 0; in particular, subtracting equal operands raises zero_o.
- R9: sign_o equals result_o[15], so sign_o=0 marks a result that is zero or positive.
- R10: a shift amount of 0 (b_i[2:0]=000) passes a_i through unchanged for both shift operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B; its low 3 bits are the shift amount |
| op_i | input | 3 | Operation code |
| result_o | output | 16 | Operation result |
| zero_o | output | 1 | High when the result is all zeros |
| sign_o | output | 1 | Most significant bit of the result |

## Verification
The path from the inputs to every output contains no register. The result, the zero flag and the sign flag are therefore all due in the same cycle in which the operands and the operation code are applied. The bench applies new inputs just after a rising clock edge and samples all three outputs at the following falling edge. By that point the combinational path has settled and no edge ordering is involved. The expected result and both flags are derived from the bench's own model or its table, never from the design.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  localparam int ALU_OP_W = 3;

  typedef enum logic [ALU_OP_W-1:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_NOT = 3'b010,
    OP_AND = 3'b011,
    OP_SLL = 3'b100,
    OP_SRL = 3'b101
  } alu_op_e;
endpackage

// File: rtl/alu16_arith.sv
module alu16_arith #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o
);
  logic [DATA_W-1:0] b_eff;

  // subtract as a + ~b + 1, wrapping
  assign b_eff = sub_i ? ~b_i : b_i;
  assign sum_o = a_i + b_eff + DATA_W'(sub_i);

  always_comb begin
    if (!sub_i) begin
      p_add_inverse_r1: assert (DATA_W'(sum_o - b_i) == a_i)
        else $error("add result inconsistent");
    end else begin
      p_sub_inverse_r2: assert (DATA_W'(sum_o + b_i) == a_i)
        else $error("sub result inconsistent");
    end
  end
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] not_o,
  output logic [DATA_W-1:0] and_o
);
  assign not_o = ~a_i;
  assign and_o = a_i & b_i;

  always_comb begin
    p_not_disjoint_r3: assert (((not_o & a_i) == '0) && ((not_o | a_i) == '1))
      else $error("complement not disjoint from operand");
    p_and_subset_r4: assert (((and_o & ~a_i) == '0) && ((and_o & ~b_i) == '0))
      else $error("and result has bits outside operands");
  end
endmodule

// File: rtl/alu16_shift.sv
module alu16_shift #(
  parameter int DATA_W  = 16,
  parameter int SHAMT_W = 3,
  parameter bit LEFT    = 1'b1
) (
  input  logic [DATA_W-1:0]  a_i,
  input  logic [SHAMT_W-1:0] amt_i,
  output logic [DATA_W-1:0]  res_o
);
  logic [DATA_W-1:0] stage [SHAMT_W+1];
  logic [DATA_W-1:0] fill_mask;

  assign stage[0] = a_i;

  // log-depth barrel: stage s shifts by 2**s when amt bit s is set
  for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    if (LEFT) begin : g_l
      assign stage[s+1] = amt_i[s] ? (stage[s] << STEP) : stage[s];
    end else begin : g_r
      assign stage[s+1] = amt_i[s] ? (stage[s] >> STEP) : stage[s];
    end
  end

  assign res_o = stage[SHAMT_W];

  // bits that must have been filled with zeros
  if (LEFT) begin : g_mask_l
    assign fill_mask = (DATA_W'(1) << amt_i) - DATA_W'(1);
  end else begin : g_mask_r
    assign fill_mask = ~({DATA_W{1'b1}} >> amt_i);
  end

  always_comb begin
    if (LEFT) begin
      p_sll_zero_fill_r5: assert ((res_o & fill_mask) == '0)
        else $error("left shift did not fill zeros");
    end else begin
      p_srl_zero_fill_r6: assert ((res_o & fill_mask) == '0)
        else $error("right shift did not fill zeros");
    end
    if (amt_i == '0) begin
      p_shift_pass_r10: assert (res_o == a_i)
        else $error("zero shift changed operand");
    end
  end
endmodule

// File: rtl/alu16_flags.sv
module alu16_flags #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] res_i,
  output logic              zero_o,
  output logic              sign_o
);
  assign zero_o = ~|res_i;
  assign sign_o = res_i[DATA_W-1];

  always_comb begin
    if (zero_o) begin
      p_zero_not_neg_r9: assert (!sign_o)
        else $error("zero result flagged negative");
    end
  end
endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int SHAMT_W = 3
) (
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  input  logic [ALU_OP_W-1:0] op_i,
  output logic [DATA_W-1:0]   result_o,
  output logic                zero_o,
  output logic                sign_o
);
  alu_op_e           op;
  logic [DATA_W-1:0] arith_res, not_res, and_res, sll_res, srl_res;

  assign op = alu_op_e'(op_i);

  alu16_arith #(.DATA_W(DATA_W)) u_arith (
    .a_i  (a_i),
    .b_i  (b_i),
    .sub_i(op == OP_SUB),
    .sum_o(arith_res)
  );

  alu16_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i  (a_i),
    .b_i  (b_i),
    .not_o(not_res),
    .and_o(and_res)
  );

  alu16_shift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .LEFT(1'b1)) u_sll (
    .a_i  (a_i),
    .amt_i(b_i[SHAMT_W-1:0]),
    .res_o(sll_res)
  );

  alu16_shift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .LEFT(1'b0)) u_srl (
    .a_i  (a_i),
    .amt_i(b_i[SHAMT_W-1:0]),
    .res_o(srl_res)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_SUB: result_o = arith_res;
      OP_NOT:         result_o = not_res;
      OP_AND:         result_o = and_res;
      OP_SLL:         result_o = sll_res;
      OP_SRL:         result_o = srl_res;
      default:        result_o = '0;
    endcase
  end

  alu16_flags #(.DATA_W(DATA_W)) u_flags (
    .res_i (result_o),
    .zero_o(zero_o),
    .sign_o(sign_o)
  );

  always_comb begin
    if (op_i[2] && op_i[1]) begin
      p_unused_code_zero_r7: assert (result_o == '0 && zero_o)
        else $error("unused code gave nonzero result");
    end
    if (op == OP_SUB && a_i == b_i) begin
      p_equal_sets_zero_r8: assert (zero_o)
        else $error("equal operands did not raise zero");
    end
  end
endmodule

// File: tb/tb_alu16_core.sv
module tb_alu16_core;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] a, b, res;
  logic [2:0]  op;
  logic        zero, sign;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  alu16_core dut (
    .a_i(a), .b_i(b), .op_i(op),
    .result_o(res), .zero_o(zero), .sign_o(sign)
  );

  // {op, a, b, expected}
  localparam int NV = 14;
  localparam logic [50:0] VEC [NV] = '{
    {3'd0, 16'h1234, 16'h0101, 16'h1335},
    {3'd0, 16'hFFFF, 16'h0002, 16'h0001},
    {3'd1, 16'h0005, 16'h0007, 16'hFFFE},
    {3'd1, 16'h8000, 16'h0001, 16'h7FFF},
    {3'd2, 16'h00FF, 16'h1234, 16'hFF00},
    {3'd3, 16'hF0F0, 16'h3C3C, 16'h3030},
    {3'd4, 16'h0001, 16'h0007, 16'h0080},
    {3'd4, 16'h8421, 16'hFFF9, 16'h0842},
    {3'd5, 16'h8000, 16'h0003, 16'h1000},
    {3'd5, 16'hFFFF, 16'h0007, 16'h01FF},
    {3'd6, 16'hFFFF, 16'hFFFF, 16'h0000},
    {3'd7, 16'h1234, 16'h0001, 16'h0000},
    {3'd4, 16'hABCD, 16'h0000, 16'hABCD},
    {3'd5, 16'hABCD, 16'h0008, 16'hABCD}
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 1:    return "R1";
      2, 3:    return "R2";
      4:       return "R3";
      5:       return "R4";
      6, 7:    return "R5";
      8, 9:    return "R6";
      10, 11:  return "R7";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [15:0] model(logic [2:0] o, logic [15:0] x, logic [15:0] y);
    case (o)
      3'd0:    return x + y;
      3'd1:    return x - y;
      3'd2:    return ~x;
      3'd3:    return x & y;
      3'd4:    return x << y[2:0];
      3'd5:    return x >> y[2:0];
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] exp);
    checks++;
    if (res !== exp || zero !== (exp == 16'h0) || sign !== exp[15]) begin
      errors++;
      $display("FAIL %s: op=%0d a=%h b=%h got res=%h z=%b s=%b exp res=%h z=%b s=%b",
               tag, op, a, b, res, zero, sign, exp, exp == 16'h0, exp[15]);
    end
  endtask

  task automatic apply(logic [2:0] o, logic [15:0] x, logic [15:0] y);
    @(posedge clk);
    #1;
    op = o; a = x; b = y;
    @(negedge clk);  // combinational: due same cycle
  endtask

  initial begin
    #40000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    op = 3'd0; a = '0; b = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // idle state: add of zeros
    apply(3'd0, 16'h0, 16'h0);
    check("R8", 16'h0000);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][50:48], VEC[i][47:32], VEC[i][31:16]);
      check(vec_tag(i), VEC[i][15:0]);
    end

    // R8: equality by subtraction
    apply(3'd1, 16'h4242, 16'h4242);
    check("R8", 16'h0000);
    apply(3'd1, 16'h4242, 16'h4243);
    check("R8", 16'hFFFF);
    // R9: sign from msb
    apply(3'd0, 16'h7FFF, 16'h0001);
    check("R9", 16'h8000);
    apply(3'd1, 16'h0003, 16'h0005);
    check("R9", 16'hFFFE);
    apply(3'd3, 16'h7FFF, 16'hFFFF);
    check("R9", 16'h7FFF);
    // R3: B ignored for complement
    apply(3'd2, 16'h5A5A, 16'h0000);
    check("R3", 16'hA5A5);
    apply(3'd2, 16'h5A5A, 16'hFFFF);
    check("R3", 16'hA5A5);
    // R6: srl with upper B bits set
    apply(3'd5, 16'hF00F, 16'hFFFC);
    check("R6", 16'h0F00);

    // sweep every code over pseudo-random operands
    lf = 16'hACE1;
    for (int o = 0; o < 8; o++) begin
      for (int k = 0; k < 16; k++) begin
        logic [15:0] x, y;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        x = lf;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        y = lf ^ 16'h3C96;
        apply(3'(o), x, y);
        case (o)
          0: check("R1", model(3'(o), x, y));
          1: check("R2", model(3'(o), x, y));
          2: check("R3", model(3'(o), x, y));
          3: check("R4", model(3'(o), x, y));
          4: check("R5", model(3'(o), x, y));
          5: check("R6", model(3'(o), x, y));
          default: check("R7", model(3'(o), x, y));
        endcase
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule